// File: doc/BRIEF.md
# Receive FIFO Error Status Tracker

This block sits between a serial receiver and the host. Each received character enters a first-in first-out store with three error flags: break, framing and parity. The flags travel with the data through the store. Four sticky status bits report to the host: break, framing, parity and overrun. A push that arrives while the store is full is dropped, and that drop sets the overrun bit.

The host chooses when the three character flags reach the status bits. In normal mode a character's flags are merged when the host pops that character from the store, so the status matches the data being read. In accumulate mode the flags are merged when the character is pushed in. This warns the host of a bad character up to a full store's worth of characters before it reaches the head, but it no longer shows which character was bad. A clear command zeroes all four bits. A flush empties the store and discards every unread character.

Top module: `rx_err_tracker`

## Requirements
- R1: After reset the store is empty (`fifo_empty`=1, `fifo_full`=0) and `err_status` is 4'b0000.
- R2: Characters leave in the order they were accepted. `pop_data` shows the oldest stored character whenever the store is not empty. A pop is accepted only when the store is not empty, and a pop on an empty store changes nothing.
- R3: `fifo_full` is 1 when DEPTH characters are stored. A push while full is dropped even if a pop is accepted in the same cycle, the stored characters are kept, and `err_status[0]` (overrun) is 1 from the next cycle.
- R4: With `accum_mode`=0, an accepted pop ORs the popped character's flags into `err_status[3]` (break), `err_status[2]` (framing) and `err_status[1]` (parity) for the next cycle. Pushes in this mode leave those bits unchanged.
- R5: With `accum_mode`=1, an accepted push ORs the pushed flags into `err_status[3:1]` for the next cycle. Pops in this mode leave those bits unchanged.
- R6: A cycle with `clr_err`=1 makes `err_status` 4'b0000 in the next cycle. This holds even if a push, a pop or an overrun sets a bit in that same cycle.
- R7: A cycle with `rx_flush`=1 empties the store by the next cycle. A push or pop presented in that cycle is ignored, and it neither sets nor changes any status bit.
- R8: Status bits are sticky. A set bit stays set until a clear command or reset.
- R9: Changing `accum_mode` does not alter stored characters or bits already set. Each later push or pop follows the mode present in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| accum_mode | input | 1 | 1: merge flags at push; 0: merge flags at pop |
| clr_err | input | 1 | Clear all four status bits |
| rx_flush | input | 1 | Discard all stored characters |
| push_vld | input | 1 | Push request for one character |
| push_data | input | DATA_W | Character to push |
| push_brk | input | 1 | Break flag of the pushed character |
| push_frm | input | 1 | Framing flag of the pushed character |
| push_par | input | 1 | Parity flag of the pushed character |
| pop_req | input | 1 | Pop request for the head character |
| pop_data | output | DATA_W | Head character (valid when not empty) |
| fifo_empty | output | 1 | Store holds no characters |
| fifo_full | output | 1 | Store holds DEPTH characters |
| err_status | output | 4 | {break, framing, parity, overrun} |

## Verification
The assertions assume the control inputs are synchronous and hold steady around the rising edge. They also assume that `accum_mode` is sampled in the same cycle as the push or pop it governs. Nothing constrains how often modes change or how pushes, pops, clears and flushes combine. For that reason the stimulus drives every input at the falling edge, including random mixtures in which all controls may coincide. Runs of pushes fill the store to its limit, so the full and overrun cases occur.

// File: rtl/rxe_pkg.sv
package rxe_pkg;

    // Error flags stored with every queued character
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxe_flags_t;

    // Host-visible sticky status, MSB first: break, framing, parity, overrun
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } rxe_status_t;

    localparam int FLAG_W   = 3;
    localparam int STATUS_W = 4;

endpackage

// File: rtl/rxe_fifo.sv
module rxe_fifo
    import rxe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  rxe_flags_t        push_flags,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output rxe_flags_t        head_flags,
    output logic              empty,
    output logic              full,
    output logic              push_acc,
    output logic              pop_acc,
    output logic              ovf
);

    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int ENT_W = DATA_W + FLAG_W;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_q, ptr_d;
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic [ENT_W-1:0] head_ent;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty    = (ptr_q.cnt == '0);
    assign full     = (ptr_q.cnt == CW'(DEPTH));
    assign push_acc = push & ~full & ~flush;
    assign pop_acc  = pop & ~empty & ~flush;
    assign ovf      = push & full & ~flush;

    assign head_ent   = mem_q[ptr_q.rd];
    assign head_data  = head_ent[ENT_W-1:FLAG_W];
    assign head_flags = rxe_flags_t'(head_ent[FLAG_W-1:0]);

    always_comb begin
        ptr_d = ptr_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (push_acc) ptr_d.wr = wrap_inc(ptr_q.wr);
            if (pop_acc)  ptr_d.rd = wrap_inc(ptr_q.rd);
            ptr_d.cnt = ptr_q.cnt + CW'(push_acc) - CW'(pop_acc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push_acc) mem_q[ptr_q.wr] <= {push_data, push_flags};
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R7

    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> full); // R3

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.cnt <= CW'(DEPTH)); // R3

    AST_EMPTY_POP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push && !flush) |=> empty); // R2

endmodule

// File: rtl/rxe_status.sv
module rxe_status
    import rxe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accum_mode,
    input  logic        clr,
    input  logic        push_acc,
    input  rxe_flags_t  push_flags,
    input  logic        pop_acc,
    input  rxe_flags_t  pop_flags,
    input  logic        ovf,
    output rxe_status_t status
);

    typedef struct packed {
        rxe_status_t st;
    } st_reg_t;

    st_reg_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!accum_mode && pop_acc) begin
            st_d.st.brk = st_q.st.brk | pop_flags.brk;
            st_d.st.frm = st_q.st.frm | pop_flags.frm;
            st_d.st.par = st_q.st.par | pop_flags.par;
        end
        if (accum_mode && push_acc) begin
            st_d.st.brk = st_d.st.brk | push_flags.brk;
            st_d.st.frm = st_d.st.frm | push_flags.frm;
            st_d.st.par = st_d.st.par | push_flags.par;
        end
        if (ovf) st_d.st.ovr = 1'b1;
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.st;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status == '0)); // R6

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status & $past(status)) == $past(status))); // R8

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> status.ovr); // R3

    AST_POP_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!accum_mode && pop_acc && !clr)
        |=> (({status.brk, status.frm, status.par} & $past(pop_flags)) == $past(pop_flags))); // R4

    AST_PUSH_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (accum_mode && push_acc && !clr)
        |=> (({status.brk, status.frm, status.par} & $past(push_flags)) == $past(push_flags))); // R5

    AST_ACCUM_POP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (accum_mode && pop_acc && !push_acc && !ovf && !clr) |=> $stable(status)); // R5

    AST_NORMAL_PUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!accum_mode && push_acc && !pop_acc && !ovf && !clr) |=> $stable(status)); // R4

endmodule

// File: rtl/rx_err_tracker.sv
module rx_err_tracker
    import rxe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accum_mode,
    input  logic              clr_err,
    input  logic              rx_flush,
    input  logic              push_vld,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_brk,
    input  logic              push_frm,
    input  logic              push_par,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic [3:0]        err_status
);

    rxe_flags_t  in_flags, head_flags;
    rxe_status_t status;
    logic        push_acc, pop_acc, ovf;

    assign in_flags = '{brk: push_brk, frm: push_frm, par: push_par};

    rxe_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (rx_flush),
        .push       (push_vld),
        .push_data  (push_data),
        .push_flags (in_flags),
        .pop        (pop_req),
        .head_data  (pop_data),
        .head_flags (head_flags),
        .empty      (fifo_empty),
        .full       (fifo_full),
        .push_acc   (push_acc),
        .pop_acc    (pop_acc),
        .ovf        (ovf)
    );

    rxe_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .accum_mode (accum_mode),
        .clr        (clr_err),
        .push_acc   (push_acc),
        .push_flags (in_flags),
        .pop_acc    (pop_acc),
        .pop_flags  (head_flags),
        .ovf        (ovf),
        .status     (status)
    );

    assign err_status = status;

    AST_FLUSH_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush && !clr_err) |=> $stable(err_status)); // R7

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full)); // R3

endmodule

// File: tb/rx_err_tracker_test.sv
`timescale 1ns/1ps
module rx_err_tracker_test;

    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       accum_mode = 1'b0, clr_err = 1'b0, rx_flush = 1'b0;
    logic       push_vld = 1'b0, push_brk = 1'b0, push_frm = 1'b0, push_par = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_req = 1'b0;
    logic [7:0] pop_data;
    logic       fifo_empty, fifo_full;
    logic [3:0] err_status;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    logic [10:0] mq[$];   // {data, brk, frm, par}
    logic [3:0]  mst = '0;

    always #4 clk = ~clk;

    rx_err_tracker #(.DATA_W(8), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .accum_mode(accum_mode), .clr_err(clr_err),
        .rx_flush(rx_flush), .push_vld(push_vld), .push_data(push_data),
        .push_brk(push_brk), .push_frm(push_frm), .push_par(push_par),
        .pop_req(pop_req), .pop_data(pop_data), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .err_status(err_status)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(cur_req, "empty", 32'(fifo_empty), 32'(mq.size() == 0));
        chk(cur_req, "full", 32'(fifo_full), 32'(mq.size() == DEPTH));
        chk(cur_req, "status", 32'(err_status), 32'(mst));
        if (mq.size() > 0) chk(cur_req, "head data", 32'(pop_data), 32'(mq[0][10:3]));
    endtask

    task automatic model_update();
        logic [10:0] head;
        logic [3:0]  nst;
        bit pok, qok, ov;
        nst = mst;
        if (!rx_flush) begin
            pok = pop_req && (mq.size() > 0);
            qok = push_vld && (mq.size() < DEPTH);
            ov  = push_vld && (mq.size() == DEPTH);
            head = (mq.size() > 0) ? mq[0] : '0;
            if (pok) void'(mq.pop_front());
            if (qok) mq.push_back({push_data, push_brk, push_frm, push_par});
            if (!accum_mode && pok) nst[3:1] = nst[3:1] | head[2:0];
            if (accum_mode && qok) nst[3:1] = nst[3:1] | {push_brk, push_frm, push_par};
            if (ov) nst[0] = 1'b1;
        end else begin
            mq.delete();
        end
        if (clr_err) nst = '0;
        mst = nst;
    endtask

    task automatic step(bit p, logic [7:0] d, logic [2:0] f, bit r, bit c, bit fl);
        push_vld = p; push_data = d; {push_brk, push_frm, push_par} = f;
        pop_req = r; clr_err = c; rx_flush = fl;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        push_vld = 0; pop_req = 0; clr_err = 0; rx_flush = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        compare();

        // R2: ordering, empty pop ignored
        cur_req = "R2";
        step(0, 8'h00, 3'b000, 1, 0, 0);
        for (int i = 0; i < 5; i++) step(1, 8'(8'h10 + i), 3'b000, 0, 0, 0);
        for (int i = 0; i < 6; i++) step(0, 8'h00, 3'b000, 1, 0, 0);

        // R4: normal mode, push leaves status, pop folds flags
        cur_req = "R4";
        accum_mode = 0;
        step(1, 8'hA1, 3'b010, 0, 0, 0);
        step(1, 8'hA2, 3'b001, 0, 0, 0);
        step(0, 8'h00, 3'b000, 1, 0, 0);
        step(0, 8'h00, 3'b000, 1, 0, 0);

        // R8: sticky bits hold over idle cycles
        cur_req = "R8";
        for (int i = 0; i < 4; i++) step(0, 8'h00, 3'b000, 0, 0, 0);

        // R6: clear wins over a same-cycle set
        cur_req = "R6";
        step(1, 8'hB0, 3'b100, 0, 0, 0);
        step(0, 8'h00, 3'b000, 1, 1, 0);

        // R5: accumulate mode folds at push, pop quiet
        cur_req = "R5";
        accum_mode = 1;
        step(1, 8'hC1, 3'b100, 0, 0, 0);
        step(0, 8'h00, 3'b000, 0, 1, 0);
        step(0, 8'h00, 3'b000, 1, 0, 0);

        // R9: entries queued in normal mode popped in accumulate mode
        cur_req = "R9";
        accum_mode = 0;
        step(1, 8'hD1, 3'b111, 0, 0, 0);
        accum_mode = 1;
        step(0, 8'h00, 3'b000, 1, 0, 0);
        step(1, 8'hD2, 3'b010, 0, 0, 0);
        accum_mode = 0;
        step(0, 8'h00, 3'b000, 1, 0, 0);
        step(0, 8'h00, 3'b000, 0, 1, 0);

        // R3: fill, overflow (also with a pop), drain intact
        cur_req = "R3";
        for (int i = 0; i < DEPTH; i++) step(1, 8'(i), 3'(i % 3 == 0 ? 3'b001 : 3'b000), 0, 0, 0);
        step(1, 8'hEE, 3'b100, 0, 0, 0);
        step(1, 8'hEF, 3'b100, 1, 0, 0);
        for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 3'b000, 1, 0, 0);

        // R7: flush discards, same-cycle push ignored, status kept
        cur_req = "R7";
        for (int i = 0; i < 4; i++) step(1, 8'(8'h50 + i), 3'b000, 0, 0, 0);
        step(1, 8'h77, 3'b111, 1, 0, 1);
        step(0, 8'h00, 3'b000, 1, 0, 0);

        // R2: random mixture of all controls
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            accum_mode = ($urandom_range(0, 3) == 0);
            step($urandom_range(0, 2) != 0, 8'($urandom), 3'($urandom),
                 $urandom_range(0, 2) == 0, $urandom_range(0, 40) == 0,
                 $urandom_range(0, 80) == 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: cycles actual 100000 expected fewer");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule